// File: doc/BRIEF.md
# Streaming Hamming Page ECC Engine

This block guards NAND page data with a single-error-correcting, double-error-detecting Hamming code, one code per 512-byte block. Bytes stream through it one per cycle with valid, first and last flags, a byte address and a direction bit. A block begins only when a valid first byte arrives at an address whose low nine bits are zero. From then on every valid byte is folded into 24 parity bits. The bytes are indexed 0 to 511 in the order they arrive.

On a write block the engine presents the 24-bit code, as three bytes, for one cycle after the last byte. The surrounding logic stores that code in the spare area behind the page data. On a read block the engine waits for the code read back from the spare area. It then reports one of four outcomes: clean, a correctable single data-bit error with its byte and bit position, a single flipped bit inside the stored code, or an uncorrectable error. The report is held until the next block begins. Correcting the buffered data is left to the caller.

The controller has four states. `ST_IDLE` ignores everything except an aligned start. `ST_ACCUM` folds bytes until the last flag. `ST_EMIT` presents the write code for one cycle. `ST_WAIT_CODE` waits for the stored code. The transitions are:
- An aligned start goes from any state to `ST_ACCUM`, or directly to `ST_EMIT`/`ST_WAIT_CODE` when that start byte is also last.
- A last byte goes from `ST_ACCUM` to `ST_EMIT` (write) or to `ST_WAIT_CODE` (read).
- `ST_EMIT` goes back to `ST_IDLE` after one cycle.
- The stored code arriving goes from `ST_WAIT_CODE` to `ST_IDLE`.

Top module: `nand_page_ecc`

## Requirements
- R1: After reset, code_valid and st_valid are 0.
- R2: A block starts only on a cycle with in_valid=1, in_first=1 and in_addr[8:0]=0. While idle, every other byte is ignored: no code appears and the status does not change.
- R3: The bit position of a data bit is p = byte_index*8 + bit_index (12 bits). For each k in 0..11, code bit 2k+1 is the inverted XOR of all data bits whose p has bit k set, and code bit 2k is the inverted XOR of all data bits whose p has bit k clear. code_out[7:0], [15:8] and [23:16] are the three code bytes.
- R4: On a write block, code_valid is 1 for exactly the cycle after the last byte is accepted, and code_out then carries the R3 code of the block.
- R5: A block of 512 bytes of 0xFF yields the code 0xFFFFFF.
- R6: On a read block, the engine waits after the last byte for cmp_valid. The status is registered on that edge, and st_valid is 1 from the next cycle on.
- R7: A syndrome (computed code XOR cmp_code) of zero reports st_type=2'b00.
- R8: A syndrome whose 12 bit pairs all differ reports st_type=2'b01, with st_byte and st_bit giving the flipped data bit's byte index and bit index.
- R9: A syndrome with exactly one bit set reports st_type=2'b10, with st_byte=0 and st_bit=0.
- R10: Any other non-zero syndrome reports st_type=2'b11, with st_byte=0 and st_bit=0.
- R11: An aligned start in any state discards the partial sums and the byte index of the old block, and clears st_valid on the same edge.
- R12: The status holds its value until the next aligned start. A cmp_valid outside the wait state has no effect.
- R13: When the start byte of the next block arrives in the cycle that shows a write code, that code is still correct, and the new block is computed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present this cycle |
| in_first | input | 1 | Byte is the first of a block |
| in_last | input | 1 | Byte is the last of a block |
| in_write | input | 1 | Direction for the block being started: 1 write, 0 read |
| in_addr | input | ADDR_W | Byte address of the current byte |
| in_data | input | 8 | Data byte |
| cmp_valid | input | 1 | Stored code is present on cmp_code |
| cmp_code | input | 24 | Code read back from the spare area |
| code_valid | output | 1 | code_out holds a write block's code |
| code_out | output | 24 | Computed code, three bytes |
| st_valid | output | 1 | Read status is valid |
| st_type | output | 2 | Outcome: 00 clean, 01 data bit, 10 code bit, 11 uncorrectable |
| st_byte | output | 9 | Byte index of the correctable error |
| st_bit | output | 3 | Bit index of the correctable error |

## Verification
Two functions can fall in the same cycle: showing a finished write block's code, and accepting the start byte of the next block. A second pair is a stored code arriving while a new block starts. The bench provokes the first pair by driving block B's first byte in the cycle where block A's code is visible. It then compares A's code in that cycle and B's code at its own end against a bench-side parity model. Restart-mid-block and status-clearing cases are judged the same way, against the model code of the block that was actually started.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCUM,
        ST_EMIT,
        ST_WAIT_CODE
    } ecc_state_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'b00,
        ERR_DATA_FIX = 2'b01,
        ERR_IN_CODE  = 2'b10,
        ERR_UNCORR   = 2'b11
    } ecc_err_e;

    // Lanes of a byte whose bit index has bit k set.
    function automatic logic [7:0] lane_mask(input int k);
        logic [7:0] m;
        for (int b = 0; b < 8; b++) begin
            m[b] = ((b >> k) & 1) == 1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_parity_acc.sv
module ecc_parity_acc #(
    parameter int BLK_LOG2 = 9,
    localparam int POS_W   = BLK_LOG2 + 3,
    localparam int CODE_W  = 2 * POS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic [BLK_LOG2-1:0] idx,
    input  logic [7:0]          data,
    output logic [CODE_W-1:0]   par
);
    import nand_ecc_pkg::*;

    logic              byte_par;
    logic [CODE_W-1:0] contrib;

    assign byte_par = ^data;

    for (genvar k = 0; k < POS_W; k++) begin : g_pos
        if (k < 3) begin : g_col
            assign contrib[2*k+1] = ^(data & lane_mask(k));
            assign contrib[2*k]   = ^(data & ~lane_mask(k));
        end else begin : g_row
            assign contrib[2*k+1] = idx[k-3] & byte_par;
            assign contrib[2*k]   = ~idx[k-3] & byte_par;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par <= '0;
        end else if (en) begin
            par <= (clr ? '0 : par) ^ contrib;
        end else if (clr) begin
            par <= '0;
        end
    end

endmodule

// File: rtl/ecc_syndrome_dec.sv
module ecc_syndrome_dec #(
    parameter int BLK_LOG2 = 9,
    localparam int POS_W   = BLK_LOG2 + 3,
    localparam int CODE_W  = 2 * POS_W
) (
    input  logic [CODE_W-1:0]   calc_code,
    input  logic [CODE_W-1:0]   stored_code,
    output logic [1:0]          err_type,
    output logic [BLK_LOG2-1:0] err_byte,
    output logic [2:0]          err_bit
);
    import nand_ecc_pkg::*;

    logic [CODE_W-1:0] syn;
    logic [POS_W-1:0]  pair_diff;
    logic [POS_W-1:0]  odd_half;

    assign syn = calc_code ^ stored_code;

    for (genvar k = 0; k < POS_W; k++) begin : g_pair
        assign pair_diff[k] = syn[2*k+1] ^ syn[2*k];
        assign odd_half[k]  = syn[2*k+1];
    end

    always_comb begin
        err_byte = '0;
        err_bit  = '0;
        if (syn == '0) begin
            err_type = ERR_NONE;
        end else if (&pair_diff) begin
            err_type = ERR_DATA_FIX;
            err_byte = odd_half[POS_W-1:3];
            err_bit  = odd_half[2:0];
        end else if ($countones(syn) == 1) begin
            err_type = ERR_IN_CODE;
        end else begin
            err_type = ERR_UNCORR;
        end
    end

endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc #(
    parameter int ADDR_W   = 32,
    parameter int BLK_LOG2 = 9,
    localparam int POS_W   = BLK_LOG2 + 3,
    localparam int CODE_W  = 2 * POS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_first,
    input  logic                in_last,
    input  logic                in_write,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [7:0]          in_data,
    input  logic                cmp_valid,
    input  logic [CODE_W-1:0]   cmp_code,
    output logic                code_valid,
    output logic [CODE_W-1:0]   code_out,
    output logic                st_valid,
    output logic [1:0]          st_type,
    output logic [BLK_LOG2-1:0] st_byte,
    output logic [2:0]          st_bit
);
    import nand_ecc_pkg::*;

    ecc_state_e          state_q, state_d;
    logic                dir_wr_q;
    logic [BLK_LOG2-1:0] idx_q;
    logic                start, acc_en, dir_now;
    logic [CODE_W-1:0]   par;
    logic [1:0]          dec_type;
    logic [BLK_LOG2-1:0] dec_byte;
    logic [2:0]          dec_bit;

    assign start   = in_valid && in_first && (in_addr[BLK_LOG2-1:0] == '0);
    assign acc_en  = start || (state_q == ST_ACCUM && in_valid);
    assign dir_now = start ? in_write : dir_wr_q;

    ecc_parity_acc #(.BLK_LOG2(BLK_LOG2)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (start),
        .en   (acc_en),
        .idx  (start ? '0 : idx_q),
        .data (in_data),
        .par  (par)
    );

    ecc_syndrome_dec #(.BLK_LOG2(BLK_LOG2)) u_dec (
        .calc_code  (~par),
        .stored_code(cmp_code),
        .err_type   (dec_type),
        .err_byte   (dec_byte),
        .err_bit    (dec_bit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = in_last ? (in_write ? ST_EMIT : ST_WAIT_CODE) : ST_ACCUM;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ACCUM:     if (in_valid && in_last)
                                  state_d = dir_now ? ST_EMIT : ST_WAIT_CODE;
                ST_EMIT:      state_d = ST_IDLE;
                ST_WAIT_CODE: if (cmp_valid) state_d = ST_IDLE;
            endcase
        end
    end

    // State register with block bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dir_wr_q <= 1'b0;
            idx_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                dir_wr_q <= in_write;
                idx_q    <= BLK_LOG2'(1);
            end else if (acc_en) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Status register
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            st_valid <= 1'b0;
            st_type  <= ERR_NONE;
            st_byte  <= '0;
            st_bit   <= '0;
        end else if (state_q == ST_WAIT_CODE && cmp_valid) begin
            st_valid <= 1'b1;
            st_type  <= dec_type;
            st_byte  <= dec_byte;
            st_bit   <= dec_bit;
        end
    end

    // Outputs decoded from state
    always_comb begin
        code_valid = (state_q == ST_EMIT);
        code_out   = ~par;
    end

endmodule

// File: rtl/nand_page_ecc_chk.sv
module nand_page_ecc_chk #(
    parameter int ADDR_W   = 32,
    parameter int BLK_LOG2 = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_first,
    input logic [ADDR_W-1:0]   in_addr,
    input logic                cmp_valid,
    input logic                code_valid,
    input logic                st_valid,
    input logic [1:0]          st_type,
    input logic [BLK_LOG2-1:0] st_byte,
    input logic [2:0]          st_bit
);
    logic aligned_start;
    assign aligned_start = in_valid && in_first && (in_addr[BLK_LOG2-1:0] == '0);

    assert_rise_after_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_valid) |-> $past(cmp_valid));

    assert_clear_on_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_valid) |-> $past(aligned_start));

    assert_hold_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && $past(st_valid)) |-> ($stable(st_type) && $stable(st_byte) && $stable(st_bit)));

    // R9 and R10: no location unless the error is a correctable data bit
    assert_loc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_type != 2'b01) |-> (st_byte == '0 && st_bit == '0));

    assert_write_no_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid |-> !st_valid);

endmodule

bind nand_page_ecc nand_page_ecc_chk #(.ADDR_W(ADDR_W), .BLK_LOG2(BLK_LOG2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_addr   (in_addr),
    .cmp_valid (cmp_valid),
    .code_valid(code_valid),
    .st_valid  (st_valid),
    .st_type   (st_type),
    .st_byte   (st_byte),
    .st_bit    (st_bit)
);

// File: tb/sim_nand_page_ecc.sv
module sim_nand_page_ecc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 0, in_first = 0, in_last = 0, in_write = 0;
    logic [31:0] in_addr = '0;
    logic [7:0]  in_data = '0;
    logic        cmp_valid = 0;
    logic [23:0] cmp_code = '0;
    logic        code_valid, st_valid;
    logic [23:0] code_out;
    logic [1:0]  st_type;
    logic [8:0]  st_byte;
    logic [2:0]  st_bit;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] buf_a [512];

    always #5 clk = ~clk;

    nand_page_ecc u0 (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] model_code();
        logic [11:0] p1 = '0, p0 = '0;
        logic [23:0] c;
        for (int i = 0; i < 512; i++)
            for (int j = 0; j < 8; j++)
                if (buf_a[i][j]) begin
                    p1 ^= {i[8:0], j[2:0]};
                    p0 ^= ~{i[8:0], j[2:0]};
                end
        for (int k = 0; k < 12; k++) begin
            c[2*k+1] = ~p1[k];
            c[2*k]   = ~p0[k];
        end
        return c;
    endfunction

    task automatic fill_rand();
        for (int i = 0; i < 512; i++) buf_a[i] = 8'($urandom);
    endtask

    // Caller is at a negedge; returns at the negedge after the last byte edge.
    task automatic drive_bytes(input bit wr, input logic [31:0] base, input int n, input bit last);
        for (int i = 0; i < n; i++) begin
            in_valid = 1; in_first = (i == 0); in_last = last && (i == n - 1);
            in_write = wr; in_addr = base + 32'(i); in_data = buf_a[i];
            @(negedge clk);
        end
        in_valid = 0; in_first = 0; in_last = 0;
    endtask

    task automatic read_check(input logic [23:0] stored, input logic [1:0] et,
                              input logic [8:0] eb, input logic [2:0] ebit, input string tag);
        drive_bytes(0, 32'h0000_0400, 512, 1);
        cmp_valid = 1; cmp_code = stored;
        @(negedge clk);
        cmp_valid = 0;
        check(st_valid === 1'b1, {tag, " st_valid"}, 32'(st_valid), 1);
        check(st_type === et, {tag, " st_type"}, 32'(st_type), 32'(et));
        check(st_byte === eb && st_bit === ebit, {tag, " location"}, {20'b0, st_byte, st_bit}, {20'b0, eb, ebit});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] good, exp_a;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check(code_valid === 0 && st_valid === 0, "R1 reset outputs", {code_valid, st_valid}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2/R3/R4: random write blocks
        for (int t = 0; t < 3; t++) begin
            fill_rand();
            good = model_code();
            drive_bytes(1, 32'h0001_0000 + 32'(t) * 512, 512, 1);
            check(code_valid === 1, "R4 code_valid in emit cycle", 32'(code_valid), 1);
            check(code_out === good, "R3 write code value", 32'(code_out), 32'(good));
            @(negedge clk);
            check(code_valid === 0, "R4 code_valid one cycle", 32'(code_valid), 0);
        end

        // R5: erased block
        for (int i = 0; i < 512; i++) buf_a[i] = 8'hFF;
        drive_bytes(1, 32'h0, 512, 1);
        check(code_out === 24'hFFFFFF && code_valid, "R5 erased code", 32'(code_out), 32'hFFFFFF);
        @(negedge clk);

        // R2: unaligned first never starts a block
        fill_rand();
        drive_bytes(1, 32'h0000_0204, 512, 1);
        check(code_valid === 0, "R2 unaligned ignored", 32'(code_valid), 0);
        @(negedge clk);
        check(code_valid === 0 && st_valid === 0, "R2 unaligned ignored later", {code_valid, st_valid}, 0);

        // R12: cmp_valid while idle has no effect
        cmp_valid = 1; cmp_code = 24'h123456;
        @(negedge clk);
        cmp_valid = 0;
        check(st_valid === 0, "R12 cmp outside wait ignored", 32'(st_valid), 0);

        // R7: clean read
        fill_rand();
        good = model_code();
        read_check(good, 2'b00, 9'd0, 3'd0, "R7 clean");

        // R12: status held
        repeat (5) @(negedge clk);
        check(st_valid === 1 && st_type === 2'b00, "R12 status held", {st_valid, st_type}, 32'b100);

        // R8: single data-bit errors at random and edge positions
        for (int t = 0; t < 5; t++) begin
            int pos;
            fill_rand();
            good = model_code();
            pos = (t == 0) ? 0 : (t == 1) ? 4095 : int'($urandom % 4096);
            buf_a[pos / 8][pos % 8] = ~buf_a[pos / 8][pos % 8];
            read_check(good, 2'b01, 9'(pos / 8), 3'(pos % 8), "R8 single data bit");
        end

        // R9: one code bit flipped
        fill_rand();
        good = model_code();
        read_check(good ^ (24'h1 << ($urandom % 24)), 2'b10, 9'd0, 3'd0, "R9 code bit");

        // R10: two data bits flipped
        fill_rand();
        good = model_code();
        buf_a[3][1] = ~buf_a[3][1];
        buf_a[400][6] = ~buf_a[400][6];
        read_check(good, 2'b11, 9'd0, 3'd0, "R10 double bit");

        // R11: new start clears status on the same edge
        fill_rand();
        good = model_code();
        in_valid = 1; in_first = 1; in_write = 1; in_addr = 32'h0000_0600; in_data = buf_a[0];
        @(negedge clk);
        check(st_valid === 0, "R11 status cleared by start", 32'(st_valid), 1'b0);
        for (int i = 1; i < 512; i++) begin
            in_first = 0; in_last = (i == 511); in_addr = 32'h600 + 32'(i); in_data = buf_a[i];
            @(negedge clk);
        end
        in_valid = 0; in_last = 0;
        check(code_out === good, "R11 code after clear", 32'(code_out), 32'(good));
        @(negedge clk);

        // R11: restart mid-block discards partial sums
        fill_rand();
        drive_bytes(1, 32'h0000_0800, 100, 0);
        fill_rand();
        good = model_code();
        drive_bytes(1, 32'h0000_0A00, 512, 1);
        check(code_out === good && code_valid, "R11 restart mid-block", 32'(code_out), 32'(good));

        // R13: next block starts in the emit cycle
        fill_rand();
        exp_a = model_code();
        drive_bytes(1, 32'h0000_0C00, 512, 1);
        check(code_out === exp_a && code_valid, "R13 code A with overlap", 32'(code_out), 32'(exp_a));
        fill_rand();
        good = model_code();
        drive_bytes(1, 32'h0000_0E00, 512, 1);
        check(code_out === good && code_valid, "R13 code B after overlap", 32'(code_out), 32'(good));
        @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule